// File: doc/BRIEF.md
# Pipelined Integer Square Root

This block computes the floor square root of an unsigned 64-bit integer, together with the remainder left over. It uses the binary digit-by-digit restoring recurrence. The radicand starts as the remaining value, the partial result starts at zero, and a probe starts at the highest power of four in the word (bit 62). In each iteration the remaining value is compared with partial result plus probe. When it is not smaller, that sum is subtracted from the remaining value and the partial result gains twice the probe. The partial result then moves right by one bit and the probe moves right by two. Each of the sixteen pipeline stages performs two such iterations in sequence, which is the same work per stage as one radix-4 divider stage.

The probe schedule is fixed per stage. No leading-zero skip and no special-value exit exists, so every operand takes exactly sixteen cycles. The pipeline accepts one operand per cycle. Two requesters can therefore share it by issuing on alternate cycles, and the opaque tag that travels with each operand tells them apart.

Each stage holds a two-state slot machine, `SLOT_IDLE` or `SLOT_FULL`. On every clock the slot takes on the state of the stage above it. The named transitions are:
- fill: idle to full.
- stream: full to full.
- drain: full to idle.
- rest: idle to idle.

A synchronous reset forces every slot to `SLOT_IDLE`. Data registers load only when the slot above is full and are never reset.

Top module: `isqrt_pipe`

## Requirements
- R1: The result is the floor root: out_root*out_root <= radicand, and out_rem <= 2*out_root.
- R2: The result is exact: radicand == out_root*out_root + out_rem, with out_root 32 bits wide and out_rem 33 bits wide.
- R3: An operand presented with in_valid high in cycle c appears with out_valid high in cycle c+16, whatever its value, including 0 and 2^64-1.
- R4: A new operand is accepted in every cycle. Operands issued back to back leave on consecutive cycles, in issue order.
- R5: out_tag equals the in_tag that entered with the same operand.
- R6: out_valid is high only in cycles that correspond to an issued operand. Gaps in in_valid reappear unchanged sixteen cycles later.
- R7: After a clock edge with rst high, out_valid is low. Operands in flight at reset never emerge.
- R8: The extreme operands give fixed results: 0 gives root 0 and remainder 0; 1 gives root 1 and remainder 0; 2^64-1 gives root 2^32-1 and remainder 2^33-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_radicand | input | 64 | Unsigned radicand |
| in_tag | input | 4 | Opaque tag carried with the operand |
| out_valid | output | 1 | Result present this cycle |
| out_root | output | 32 | Floor square root |
| out_rem | output | 33 | Radicand minus root squared |
| out_tag | output | 4 | Tag of the operand that produced the result |

## Verification
A corrupted remaining value or partial result inside stage k affects only the operand passing through that stage. It shows as a broken root/remainder identity on that one result, 16-k cycles later. A slot stuck in either state shows up within sixteen cycles as a missing, extra or shifted out_valid pulse, and a tag mismatch exposes any reordering. The bench therefore sweeps every radicand from 0 to 1499, perfect squares and their neighbours, the word extremes, and random magnitudes with and without gaps. It checks each result against the identity and the floor bound, along with its arrival cycle and tag.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    // Occupancy of one pipeline slot.
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_FULL = 1'b1
    } slot_e;

    // Bit position of the power-of-four probe used by global iteration `iter`.
    function automatic int probe_pos(input int rad_w, input int iter);
        return rad_w - 2 - 2 * iter;
    endfunction

endpackage

// File: rtl/isqrt_step.sv
// One restoring iteration with a fixed probe position.
module isqrt_step #(
    parameter int RAD_W = 64,
    parameter int POS   = 62
) (
    input  logic [RAD_W-1:0] num_i,
    input  logic [RAD_W-1:0] res_i,
    output logic [RAD_W-1:0] num_o,
    output logic [RAD_W-1:0] res_o
);

    localparam logic [RAD_W-1:0] PROBE = RAD_W'(1) << POS;

    logic [RAD_W-1:0] trial;
    logic             take;

    always_comb begin
        trial = res_i + PROBE;
        take  = (num_i >= trial);
        num_o = take ? (num_i - trial) : num_i;
        res_o = take ? ((res_i >> 1) + PROBE) : (res_i >> 1);
    end

endmodule

// File: rtl/isqrt_stage.sv
// One pipeline stage: ITERS iterations followed by a register slot.
module isqrt_stage
    import isqrt_pkg::*;
#(
    parameter int RAD_W = 64,
    parameter int TAG_W = 4,
    parameter int ITERS = 2,
    parameter int FIRST = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_e            up_slot,
    input  logic [RAD_W-1:0] up_num,
    input  logic [RAD_W-1:0] up_res,
    input  logic [TAG_W-1:0] up_tag,
    output slot_e            dn_slot,
    output logic [RAD_W-1:0] dn_num,
    output logic [RAD_W-1:0] dn_res,
    output logic [TAG_W-1:0] dn_tag
);

    logic [RAD_W-1:0] num_c [ITERS+1];
    logic [RAD_W-1:0] res_c [ITERS+1];

    assign num_c[0] = up_num;
    assign res_c[0] = up_res;

    for (genvar j = 0; j < ITERS; j++) begin : g_iter
        isqrt_step #(
            .RAD_W (RAD_W),
            .POS   (probe_pos(RAD_W, FIRST + j))
        ) u_step (
            .num_i (num_c[j]),
            .res_i (res_c[j]),
            .num_o (num_c[j+1]),
            .res_o (res_c[j+1])
        );
    end

    slot_e slot_q;
    slot_e slot_d;

    // Next-state: the slot follows the slot above (fill, stream, drain, rest).
    always_comb begin
        unique case (up_slot)
            SLOT_FULL: slot_d = SLOT_FULL;
            SLOT_IDLE: slot_d = SLOT_IDLE;
            default:   slot_d = SLOT_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) slot_q <= SLOT_IDLE;
        else     slot_q <= slot_d;
    end

    // Data register, loaded only when an operand arrives.
    always_ff @(posedge clk) begin
        if (up_slot == SLOT_FULL) begin
            dn_num <= num_c[ITERS];
            dn_res <= res_c[ITERS];
            dn_tag <= up_tag;
        end
    end

    assign dn_slot = slot_q;

endmodule

// File: rtl/isqrt_pipe.sv
// Fully pipelined floor square root, fixed latency RAD_W/(2*ITERS).
module isqrt_pipe
    import isqrt_pkg::*;
#(
    parameter int RAD_W = 64,
    parameter int TAG_W = 4,
    parameter int ITERS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [RAD_W-1:0]     in_radicand,
    input  logic [TAG_W-1:0]     in_tag,
    output logic                 out_valid,
    output logic [RAD_W/2-1:0]   out_root,
    output logic [RAD_W/2:0]     out_rem,
    output logic [TAG_W-1:0]     out_tag
);

    localparam int ROOT_W = RAD_W / 2;
    localparam int REM_W  = ROOT_W + 1;
    localparam int STAGES = ROOT_W / ITERS;

    slot_e            slot_c [STAGES+1];
    logic [RAD_W-1:0] num_c  [STAGES+1];
    logic [RAD_W-1:0] res_c  [STAGES+1];
    logic [TAG_W-1:0] tag_c  [STAGES+1];

    assign slot_c[0] = in_valid ? SLOT_FULL : SLOT_IDLE;
    assign num_c[0]  = in_radicand;
    assign res_c[0]  = '0;
    assign tag_c[0]  = in_tag;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        isqrt_stage #(
            .RAD_W (RAD_W),
            .TAG_W (TAG_W),
            .ITERS (ITERS),
            .FIRST (s * ITERS)
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .up_slot (slot_c[s]),
            .up_num  (num_c[s]),
            .up_res  (res_c[s]),
            .up_tag  (tag_c[s]),
            .dn_slot (slot_c[s+1]),
            .dn_num  (num_c[s+1]),
            .dn_res  (res_c[s+1]),
            .dn_tag  (tag_c[s+1])
        );
    end

    assign out_valid = (slot_c[STAGES] == SLOT_FULL);
    assign out_root  = ROOT_W'(res_c[STAGES]);
    assign out_rem   = REM_W'(num_c[STAGES]);
    assign out_tag   = tag_c[STAGES];

endmodule

// File: rtl/isqrt_pipe_chk.sv
module isqrt_pipe_chk #(
    parameter int RAD_W  = 64,
    parameter int TAG_W  = 4,
    parameter int STAGES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [RAD_W-1:0]   in_radicand,
    input logic [TAG_W-1:0]   in_tag,
    input logic               out_valid,
    input logic [RAD_W/2-1:0] out_root,
    input logic [RAD_W/2:0]   out_rem,
    input logic [TAG_W-1:0]   out_tag
);

    logic [STAGES-1:0] sh_v;
    logic [RAD_W-1:0]  sh_rad [STAGES];
    logic [TAG_W-1:0]  sh_tag [STAGES];
    logic [RAD_W-1:0]  recon;

    always_ff @(posedge clk) begin
        if (rst) sh_v <= '0;
        else     sh_v <= {sh_v[STAGES-2:0], in_valid};
        sh_rad[0] <= in_radicand;
        sh_tag[0] <= in_tag;
        for (int i = 1; i < STAGES; i++) begin
            sh_rad[i] <= sh_rad[i-1];
            sh_tag[i] <= sh_tag[i-1];
        end
    end

    always_comb recon = RAD_W'(out_root) * RAD_W'(out_root) + RAD_W'(out_rem);

    p_floor_bound_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_rem <= {out_root, 1'b0}));

    p_identity_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (recon == sh_rad[STAGES-1]));

    // R3 and R6: valid pattern reproduced exactly STAGES cycles later
    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid == sh_v[STAGES-1]);

    // R4 and R5: tags emerge with their operand, in issue order
    p_tag_order_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_tag == sh_tag[STAGES-1]));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind isqrt_pipe isqrt_pipe_chk #(
    .RAD_W  (RAD_W),
    .TAG_W  (TAG_W),
    .STAGES (STAGES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_radicand (in_radicand),
    .in_tag      (in_tag),
    .out_valid   (out_valid),
    .out_root    (out_root),
    .out_rem     (out_rem),
    .out_tag     (out_tag)
);

// File: tb/sim_isqrt_pipe.sv
`timescale 1ns/1ps
module sim_isqrt_pipe;

    localparam int RAD_W = 64;
    localparam int TAG_W = 4;
    localparam int LAT   = 16;
    localparam int QD    = 4096;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [RAD_W-1:0] in_radicand = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic             out_valid;
    logic [31:0]      out_root;
    logic [32:0]      out_rem;
    logic [TAG_W-1:0] out_tag;

    always #10 clk = ~clk;

    isqrt_pipe #(.RAD_W(RAD_W), .TAG_W(TAG_W), .ITERS(2)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_radicand(in_radicand),
        .in_tag(in_tag), .out_valid(out_valid), .out_root(out_root),
        .out_rem(out_rem), .out_tag(out_tag)
    );

    logic [RAD_W-1:0] q_rad  [QD];
    logic [TAG_W-1:0] q_tag  [QD];
    int               q_tick [QD];
    int n_iss = 0, head = 0, tick = 0, errors = 0, checks = 0;
    bit done = 0;

    task automatic fail(input string req, input string what, input logic [65:0] act, input logic [65:0] exp);
        errors++;
        $display("FAIL %s %s: actual=%0d expected=%0d (tick %0d)", req, what, act, exp, tick);
    endtask

    task automatic check_out();
        logic expect_v;
        logic [65:0] sq;
        logic [65:0] recon;
        logic [RAD_W-1:0] r;
        expect_v = (head < n_iss) && (q_tick[head] + LAT == tick);
        checks++;
        if (out_valid !== expect_v) fail("R3/R6", "out_valid", {65'b0, out_valid}, {65'b0, expect_v});
        if (expect_v && out_valid === 1'b1) begin
            r = q_rad[head];
            sq = {34'b0, out_root} * {34'b0, out_root};
            recon = sq + {33'b0, out_rem};
            checks++;
            if (recon != {2'b0, r}) fail("R2", "root^2+rem", recon, {2'b0, r});
            checks++;
            if (out_rem > {out_root, 1'b0}) fail("R1", "rem bound", {33'b0, out_rem}, {33'b0, out_root, 1'b0});
            checks++;
            if (out_tag !== q_tag[head]) fail("R4/R5", "tag", {62'b0, out_tag}, {62'b0, q_tag[head]});
            if (r == 64'd0 || r == 64'd1 || r == '1) begin
                checks++;
                if (r == 64'd0 && (out_root != 0 || out_rem != 0))
                    fail("R8", "zero operand root", {34'b0, out_root}, 66'd0);
                if (r == 64'd1 && (out_root != 1 || out_rem != 0))
                    fail("R8", "unit operand root", {34'b0, out_root}, 66'd1);
                if (r == '1 && (out_root != 32'hFFFF_FFFF || out_rem != 33'h1_FFFF_FFFE))
                    fail("R8", "all-ones remainder", {33'b0, out_rem}, 66'h1_FFFF_FFFE);
            end
        end
        if (expect_v) head++;
    endtask

    task automatic cyc(input logic v, input logic [RAD_W-1:0] rad);
        @(negedge clk);
        check_out();
        rst = 1'b0;
        in_valid = v;
        in_radicand = rad;
        in_tag = TAG_W'(n_iss);
        if (v) begin
            q_rad[n_iss] = rad;
            q_tag[n_iss] = TAG_W'(n_iss);
            q_tick[n_iss] = tick;
            n_iss++;
        end
        tick++;
    endtask

    task automatic do_reset(input int n);
        head = n_iss;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                checks++;
                if (out_valid !== 1'b0) fail("R7", "out_valid in reset", {65'b0, out_valid}, 66'd0);
            end
            rst = 1'b1;
            in_valid = 1'b0;
            tick++;
        end
    endtask

    initial begin
        do_reset(3);
        // R7 reset state, then corners back to back (R3, R8)
        cyc(1'b0, '0);
        cyc(1'b1, 64'd0);
        cyc(1'b1, 64'd1);
        cyc(1'b1, 64'd2);
        cyc(1'b1, 64'd3);
        cyc(1'b1, 64'd4);
        cyc(1'b1, '1);
        cyc(1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
        cyc(1'b1, 64'h4000_0000_0000_0000);
        cyc(1'b1, 64'h8000_0000_0000_0000);
        cyc(1'b1, 64'hFFFF_FFFE_0000_0001);
        cyc(1'b1, 64'hFFFF_FFFE_0000_0000);
        // exhaustive small sweep, back to back (R4)
        for (int i = 0; i < 1500; i++) cyc(1'b1, 64'(i));
        // perfect squares and neighbours (R1, R2)
        for (int i = 0; i < 200; i++) begin
            logic [31:0] k;
            logic [63:0] kk;
            k = (i < 4) ? 32'hFFFF_FFFF - 32'(i) : $urandom() >> ($urandom() % 32);
            kk = {32'b0, k} * {32'b0, k};
            cyc(1'b1, kk);
            cyc(1'b1, kk - 64'd1);
            cyc(1'b1, kk + {31'b0, k, 1'b0});
        end
        // random magnitudes with gaps (R6)
        for (int i = 0; i < 1200; i++) begin
            logic v;
            logic [63:0] x;
            v = ($urandom() % 3) != 0;
            x = {$urandom(), $urandom()} >> ($urandom() % 64);
            cyc(v, x);
        end
        // mid-stream reset discards in-flight work (R7)
        for (int i = 0; i < 10; i++) cyc(1'b1, 64'(i * 977 + 5));
        do_reset(2);
        for (int i = 0; i < LAT + 4; i++) cyc(1'b0, '0);
        for (int i = 0; i < 6; i++) cyc(1'b1, 64'(i * 12345 + 7));
        cyc(1'b1, '1);
        cyc(1'b1, 64'd0);
        for (int i = 0; i < LAT + 4; i++) cyc(1'b0, '0);
        checks++;
        if (head != n_iss) fail("R3", "results outstanding", 66'(n_iss - head), 66'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule